// File: doc/BRIEF.md
# Delayed-Sample Timing Error Register

This block is a register bank for the end of a long combinational path. It captures the arriving data word twice. A main flip-flop takes it on the rising edge of the main clock. A shadow store takes it again slightly later, under a second clock that is a delayed copy of the main clock. If the data was still settling at the main edge, the two captured words differ. The block then raises a one-cycle error flag that the surrounding control can use to repeat the operation or to hold the next launch. Alongside the raw main output, the block presents a corrected word, which is the shadow copy whenever a mismatch was found.

The shadow store is selectable by parameter. It can be a level-sensitive latch that is open while the delayed clock is high, or an edge-triggered flop on the rising edge of the delayed clock. The delayed clock must rise after the main edge and fall before the next main edge.

Top module: `timing_err_reg`

## Requirements
- R1: On each rising edge of `clk_main` outside reset, `q_main` takes the value of `d_in`.
- R2: The shadow copy follows `d_in` while `clk_late` is high (latch variant, `SHADOW_LATCH=1`) or takes `d_in` on the rising edge of `clk_late` (`SHADOW_LATCH=0`). A data change after the main edge but before `clk_late` rises is therefore held by the shadow copy and not by `q_main`.
- R3: On the rising edge of `clk_main` that follows a capture, `err_flag` goes to 1 if the main and shadow words of that capture differ, and to 0 if they are equal.
- R4: A difference in any single bit sets the flag: the flag is the OR of all per-bit XOR mismatches, and this includes bit 0 and bit WIDTH-1.
- R5: On that same edge, `q_fixed` loads the shadow word when a mismatch was found and the main word otherwise.
- R6: Data that stays stable from before the main edge until `clk_late` falls never raises `err_flag`. This also holds when a late change writes the same value again.
- R7: An active-low `rst_n` asynchronously clears `q_main`, the shadow copy, `q_fixed` and `err_flag` to 0.
- R8: The flag belongs to one capture only: it stays high for exactly one `clk_main` cycle unless the next capture also mismatches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main | input | 1 | Main capture clock |
| clk_late | input | 1 | Delayed copy of the main clock, drives the shadow store |
| rst_n | input | 1 | Asynchronous reset, active low |
| d_in | input | WIDTH | Data word from the datapath |
| q_main | output | WIDTH | Word captured on the main edge |
| q_fixed | output | WIDTH | Corrected word, one cycle later: shadow copy on error, main copy otherwise |
| err_flag | output | 1 | Timing error flag for the previous capture |

## Verification
The bench models a late path by rewriting `d_in` between the main edge and the delayed edge. Single-bit flips at the LSB and MSB catch a reduction that misses an end bit, so the design would report no error for a real violation. A late rewrite with an unchanged value catches a design that flags any input activity rather than an actual difference. The cycle after each error checks that the flag drops, which exposes a sticky or stretched flag. Checking `q_fixed` against the late value exposes a restore multiplexer that picks the wrong source or has its select inverted. A reset asserted just after a violating capture checks that the pending flag is cleared along with the stored words.

// File: rtl/timing_err_pkg.sv
package timing_err_pkg;
   localparam int unsigned MAX_WIDTH = 1024;

   function automatic bit width_ok(input int unsigned w);
      return (w >= 1) && (w <= MAX_WIDTH);
   endfunction
endpackage

// File: rtl/terr_main_stage.sv
module terr_main_stage #(
   parameter int unsigned WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end
endmodule

// File: rtl/terr_shadow_stage.sv
module terr_shadow_stage #(
   parameter int unsigned WIDTH        = 16,
   parameter bit          SHADOW_LATCH = 1'b1
) (
   input  logic             clk_late,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (SHADOW_LATCH) begin : g_latch
         // open while the delayed clock is high
         always_latch begin
            if (!rst_n)        q = '0;
            else if (clk_late) q = d;
         end
      end else begin : g_flop
         always_ff @(posedge clk_late or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d;
         end
      end
   endgenerate
endmodule

// File: rtl/terr_compare_restore.sv
module terr_compare_restore #(
   parameter int unsigned WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] main_q,
   input  logic [WIDTH-1:0] shadow_q,
   output logic [WIDTH-1:0] fixed_q,
   output logic             err_q
);
   logic [WIDTH-1:0] bit_diff;

   genvar gi;
   generate
      for (gi = 0; gi < WIDTH; gi++) begin : g_cmp
         assign bit_diff[gi] = main_q[gi] ^ shadow_q[gi];
      end
   endgenerate

   logic             any_diff;
   logic [WIDTH-1:0] restore_val;

   always_comb begin
      any_diff    = |bit_diff;
      restore_val = any_diff ? shadow_q : main_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q   <= 1'b0;
         fixed_q <= '0;
      end else begin
         err_q   <= any_diff;
         fixed_q <= restore_val;
      end
   end
endmodule

// File: rtl/timing_err_reg.sv
module timing_err_reg #(
   parameter int unsigned WIDTH        = 16,
   parameter bit          SHADOW_LATCH = 1'b1
) (
   input  logic             clk_main,
   input  logic             clk_late,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] q_main,
   output logic [WIDTH-1:0] q_fixed,
   output logic             err_flag
);
   import timing_err_pkg::*;

   initial begin
      assert (width_ok(WIDTH))
         else $error("timing_err_reg: WIDTH %0d out of range", WIDTH);
   end

   logic [WIDTH-1:0] main_word;
   logic [WIDTH-1:0] shadow_word;

   terr_main_stage #(.WIDTH(WIDTH)) u_main (
      .clk   (clk_main),
      .rst_n (rst_n),
      .d     (d_in),
      .q     (main_word)
   );

   terr_shadow_stage #(.WIDTH(WIDTH), .SHADOW_LATCH(SHADOW_LATCH)) u_shadow (
      .clk_late (clk_late),
      .rst_n    (rst_n),
      .d        (d_in),
      .q        (shadow_word)
   );

   terr_compare_restore #(.WIDTH(WIDTH)) u_cmp (
      .clk      (clk_main),
      .rst_n    (rst_n),
      .main_q   (main_word),
      .shadow_q (shadow_word),
      .fixed_q  (q_fixed),
      .err_q    (err_flag)
   );

   assign q_main = main_word;
endmodule

// File: rtl/timing_err_reg_chk.sv
module timing_err_reg_chk #(
   parameter int unsigned WIDTH = 16
) (
   input logic             clk_main,
   input logic             rst_n,
   input logic [WIDTH-1:0] d_in,
   input logic [WIDTH-1:0] q_main,
   input logic [WIDTH-1:0] q_fixed,
   input logic             err_flag,
   input logic [WIDTH-1:0] shadow_word
);
   // R1: main output follows the input sampled one edge earlier
   p_main_tracks_r1: assert property (@(posedge clk_main) disable iff (!rst_n)
      $past(rst_n) |-> q_main == $past(d_in));

   // R5: on error the corrected word differs from the raw main capture
   p_fixed_on_err_r5: assert property (@(posedge clk_main) disable iff (!rst_n)
      err_flag |-> q_fixed != $past(q_main));

   // R5: without error the corrected word is the main capture
   p_fixed_clean_r5: assert property (@(posedge clk_main) disable iff (!rst_n)
      !err_flag |-> q_fixed == $past(q_main));

   // R3: flag reflects whether main and shadow held different words
   p_err_matches_diff_r3: assert property (@(posedge clk_main) disable iff (!rst_n)
      err_flag == ($past(q_main) != $past(shadow_word)));
endmodule

bind timing_err_reg timing_err_reg_chk #(.WIDTH(WIDTH)) u_chk (
   .clk_main    (clk_main),
   .rst_n       (rst_n),
   .d_in        (d_in),
   .q_main      (q_main),
   .q_fixed     (q_fixed),
   .err_flag    (err_flag),
   .shadow_word (shadow_word)
);

// File: tb/tb_timing_err_reg.sv
module tb_timing_err_reg;
   localparam int W = 16;

   logic         clk_main = 1'b0;
   logic         clk_late = 1'b0;
   logic         rst_n    = 1'b0;
   logic [W-1:0] d_in     = '0;
   logic [W-1:0] q_main, q_fixed;
   logic         err_flag;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   timing_err_reg #(.WIDTH(W), .SHADOW_LATCH(1'b1)) dut (
      .clk_main (clk_main),
      .clk_late (clk_late),
      .rst_n    (rst_n),
      .d_in     (d_in),
      .q_main   (q_main),
      .q_fixed  (q_fixed),
      .err_flag (err_flag)
   );

   // 100 MHz main clock, delayed copy lagging by 3 ns
   always #5 clk_main = ~clk_main;
   initial begin
      #3;
      forever #5 clk_late = ~clk_late;
   end

   function automatic bit exp_err(input logic [W-1:0] v, input bit late,
                                  input logic [W-1:0] lv);
      return late && (lv != v);
   endfunction

   function automatic logic [W-1:0] exp_fixed(input logic [W-1:0] v, input bit late,
                                              input logic [W-1:0] lv);
      return late ? lv : v;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                      input logic [W-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // one capture: v set before the main edge, optional late rewrite to lv
   task automatic run_op(input logic [W-1:0] v, input bit late, input logic [W-1:0] lv);
      @(negedge clk_late); #1;
      d_in = v;
      @(posedge clk_main); #1;
      chk(q_main == v, "R1 main capture", q_main, v);
      chk(err_flag == 1'b0, "R8 flag dropped after prior capture", {15'd0, err_flag}, '0);
      if (late) d_in = lv;   // arrives after main edge, before delayed edge (R2)
      @(posedge clk_main); #1;
      chk(err_flag == exp_err(v, late, lv), "R3/R4/R6 error flag",
          {15'd0, err_flag}, {15'd0, exp_err(v, late, lv)});
      chk(q_fixed == exp_fixed(v, late, lv), "R5/R2 corrected word",
          q_fixed, exp_fixed(v, late, lv));
      chk(q_main == d_in, "R1 main recapture", q_main, d_in);
   endtask

   initial begin
      #2;
      chk(q_main == '0 && q_fixed == '0 && err_flag == 1'b0, "R7 reset state",
          q_main | q_fixed, '0);
      repeat (2) @(posedge clk_main);
      @(negedge clk_late); rst_n = 1'b1;

      // directed corners
      run_op(16'h1234, 1'b0, 16'h0000);          // R6 stable data
      run_op(16'hA5A5, 1'b1, 16'hA5A4);          // R4 bit 0
      run_op(16'h0F0F, 1'b1, 16'h8F0F);          // R4 top bit
      run_op(16'h5555, 1'b1, 16'h5555);          // R6 same-value rewrite
      run_op(16'hFFFF, 1'b1, 16'h0000);          // R3 all bits
      // back-to-back errors: R8 says the flag may stay high
      @(negedge clk_late); #1; d_in = 16'h0001;
      @(posedge clk_main); #1; d_in = 16'h0002;
      @(negedge clk_late); #1; d_in = 16'h0003;
      @(posedge clk_main); #1;
      chk(err_flag == 1'b1, "R8 first of two errors", {15'd0, err_flag}, 16'd1);
      chk(q_fixed == 16'h0002, "R5 first restore", q_fixed, 16'h0002);
      d_in = 16'h0004;
      @(posedge clk_main); #1;
      chk(err_flag == 1'b1, "R8 second of two errors", {15'd0, err_flag}, 16'd1);
      chk(q_fixed == 16'h0004, "R5 second restore", q_fixed, 16'h0004);
      @(posedge clk_main); #1;
      chk(err_flag == 1'b0, "R8 flag clears", {15'd0, err_flag}, '0);

      // R7 reset right after a violating capture
      @(negedge clk_late); #1; d_in = 16'hC0DE;
      @(posedge clk_main); #1; d_in = 16'hBEEF;
      @(negedge clk_late); #1; rst_n = 1'b0;
      #1;
      chk(q_main == '0 && q_fixed == '0 && err_flag == 1'b0, "R7 async clear",
          q_main | q_fixed, '0);
      @(posedge clk_main); #1;
      chk(err_flag == 1'b0, "R7 pending error dropped", {15'd0, err_flag}, '0);
      @(negedge clk_late); rst_n = 1'b1;

      // constrained random
      void'($urandom(32'd20240611));
      for (int i = 0; i < 300; i++) begin
         logic [W-1:0] v, lv, msk;
         bit late;
         v    = W'($urandom);
         late = ($urandom % 2) == 1;
         msk  = (($urandom % 4) == 0) ? '0 : W'(1 << ($urandom % W));
         if (($urandom % 3) == 0) msk = W'($urandom);
         lv   = v ^ msk;
         run_op(v, late, lv);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog actual=%0t expected=done", $time);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end
endmodule